// File: doc/BRIEF.md
# Locked Feed Watchdog Timer

This block is a supervisory timer for a chip's reset tree. A free-running input clock goes through a fixed divide-by-four prescaler. The prescaler's tick decrements a 24-bit down-counter. Software reaches the block through four word registers. These are accessed with single-cycle read and write strobes and a 32-bit data path.

Software first sets the enable bit and, if wanted, the reset-select bit. It then programs a reload value. The watchdog only starts counting after software completes a two-write unlock to the feed register. From that point it is armed for good, and it must be fed again with the same unlock before the counter runs out.

When the counter expires, a sticky timeout flag is raised. If reset-select is set, a chip-reset output is also raised and held until the external reset. An armed, reset-selected watchdog also fires at once on a malformed unlock. This covers a wrong second value, and it covers an access to another register between the two unlock writes.

Top module: `wdog_core`

## Requirements
- R1: After `rst_n` is released, `chip_rst_o` is 0, the mode register reads 0, and the reload register and the count register both read 0xFFFFFF.
- R2: Registers are decoded on `addr[3:2]`: 0 = mode, 1 = reload, 2 = feed (write-only, reads 0), 3 = count (read-only). `rdata` is 0 when `rd_en` is low. Feeding at intervals shorter than the timeout keeps `chip_rst_o` low indefinitely.
- R3: A write to the reload register stores `wdata[23:0]`, raised to 0xFF when it is below 0xFF. The bits above bit 23 are ignored.
- R4: Mode bit 0 (enable) and bit 1 (reset-select) are writable, and bit 2 is the read-only timeout flag. Setting enable alone neither starts the counter nor permits any reset.
- R5: A valid feed is a write of 0xAA (`wdata[7:0]`) to the feed register, followed by a write of 0x55. The only accesses allowed between them are idle cycles. On the second write the count reloads from the reload register. If enable is set, the watchdog becomes armed.
- R6: While armed, the count drops by exactly one every four clocks. The first decrement lands four clocks after the feed, and the count stops at 0.
- R7: If the armed count has been 0 at one clock edge, the next edge sets mode bit 2. If reset-select is also set, that edge raises `chip_rst_o`. After a feed with reload value R, this is clock edge 4R+1.
- R8: Once `chip_rst_o` is high it stays high, even through valid feeds, until `rst_n` is asserted.
- R9: Once armed, writes to the mode register cannot clear enable or reset-select. They can still set those bits.
- R10: When armed with reset-select set, a second feed write whose value is not 0x55 raises `chip_rst_o` on the same clock edge.
- R11: A read or write of any other register between the two feed writes aborts the sequence. When armed with reset-select set, this raises `chip_rst_o`. Otherwise the sequence just returns to idle, so a following lone 0x55 write does not feed.
- R12: A malformed feed sequence has no effect on `chip_rst_o` when the watchdog is not armed or reset-select is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; also drives the prescaler |
| rst_n | input | 1 | Active-low asynchronous system reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 4 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` while `rd_en` is high |
| chip_rst_o | output | 1 | Sticky chip-reset request |

## Verification
A corrupted unlock state shows up within one access. Either a correct 0x55 write fails to reload the count, which is visible on the next count read, or `chip_rst_o` rises on the edge of the offending write. A prescaler or counter fault changes the slope of the count readback within four clocks of a feed, so the bench reads the count on every cycle after a feed. It also places the timeout on the exact edge 4R+1. A lost arm or reset-select bit is visible on a mode-register read straight after the attempted clear.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int unsigned WD_CNT_W  = 24;
    localparam int unsigned WD_DIV    = 4;
    localparam int unsigned WD_ADDR_W = 4;
    localparam int unsigned WD_DATA_W = 32;
    localparam int unsigned WD_TC_MIN = 'hFF;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;

    localparam int MODE_EN_BIT   = 0;
    localparam int MODE_RSEL_BIT = 1;
    localparam int MODE_TMO_BIT  = 2;

    typedef enum logic [1:0] {
        REG_MODE   = 2'd0,
        REG_RELOAD = 2'd1,
        REG_KICK   = 2'd2,
        REG_COUNT  = 2'd3
    } reg_idx_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_HALF = 1'b1
    } seq_st_e;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick = run;
        end else begin : g_div
            localparam int unsigned PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);

            typedef struct packed {
                logic [PW-1:0] phase;
            } pre_t;

            pre_t pre_d, pre_q;

            always_comb begin
                pre_d = pre_q;
                if (clear) begin
                    pre_d.phase = '0;
                end else if (run) begin
                    pre_d.phase = (pre_q.phase == LAST) ? '0 : pre_q.phase + 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pre_q <= '0;
                else        pre_q <= pre_d;
            end

            assign tick = run && !clear && (pre_q.phase == LAST);
        end
    endgenerate
endmodule

// File: rtl/wdog_feed_seq.sv
module wdog_feed_seq
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       kick_wr,
    input  logic       other_acc,
    input  logic [7:0] kick_val,
    output logic       feed_ok,
    output logic       feed_bad
);
    typedef struct packed {
        seq_st_e st;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d    = seq_q;
        feed_ok  = 1'b0;
        feed_bad = 1'b0;
        unique case (seq_q.st)
            SEQ_IDLE: begin
                if (kick_wr && kick_val == KEY_FIRST) seq_d.st = SEQ_HALF;
            end
            SEQ_HALF: begin
                if (kick_wr) begin
                    seq_d.st = SEQ_IDLE;
                    if (kick_val == KEY_SECOND) feed_ok  = 1'b1;
                    else                        feed_bad = 1'b1;
                end else if (other_acc) begin
                    seq_d.st = SEQ_IDLE;
                    feed_bad = 1'b1;
                end
            end
            default: seq_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: SEQ_IDLE};
        else        seq_q <= seq_d;
    end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             zero
);
    typedef struct packed {
        logic [CNT_W-1:0] val;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d.val = load_val;
        end else if (run && tick && cnt_q.val != '0) begin
            cnt_d.val = cnt_q.val - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '{val: '1};
        else        cnt_q <= cnt_d;
    end

    assign cnt  = cnt_q.val;
    assign zero = (cnt_q.val == '0);
endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W  = WD_CNT_W,
    parameter int unsigned DIV    = WD_DIV,
    parameter int unsigned DATA_W = WD_DATA_W,
    parameter int unsigned TC_MIN = WD_TC_MIN
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [WD_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic                 chip_rst_o
);
    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(TC_MIN);

    typedef struct packed {
        logic             en;
        logic             rsel;
        logic             tmo;
        logic             armed;
        logic             chip_rst;
        logic [CNT_W-1:0] reload;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    reg_idx_e         idx;
    logic             kick_wr, other_acc, feed_ok, feed_bad;
    logic             tick, cnt_zero;
    logic [CNT_W-1:0] cnt_val;
    logic             unused_bits;

    assign idx       = reg_idx_e'(addr[3:2]);
    assign kick_wr   = wr_en && (idx == REG_KICK);
    assign other_acc = (wr_en || rd_en) && (idx != REG_KICK);
    assign unused_bits = ^{wdata[DATA_W-1:CNT_W], addr[1:0]};

    wdog_feed_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .kick_wr  (kick_wr),
        .other_acc(other_acc),
        .kick_val (wdata[7:0]),
        .feed_ok  (feed_ok),
        .feed_bad (feed_bad)
    );

    wdog_prescale #(.DIV(DIV)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (ctl_q.armed),
        .clear(feed_ok),
        .tick (tick)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (feed_ok),
        .load_val(ctl_q.reload),
        .run     (ctl_q.armed),
        .tick    (tick),
        .cnt     (cnt_val),
        .zero    (cnt_zero)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en && idx == REG_MODE) begin
            if (ctl_q.armed) begin
                ctl_d.en   = ctl_q.en   | wdata[MODE_EN_BIT];
                ctl_d.rsel = ctl_q.rsel | wdata[MODE_RSEL_BIT];
            end else begin
                ctl_d.en   = wdata[MODE_EN_BIT];
                ctl_d.rsel = wdata[MODE_RSEL_BIT];
            end
        end
        if (wr_en && idx == REG_RELOAD) begin
            ctl_d.reload = (wdata[CNT_W-1:0] < FLOOR) ? FLOOR : wdata[CNT_W-1:0];
        end
        if (feed_ok && ctl_q.en) ctl_d.armed = 1'b1;
        if (feed_bad && ctl_q.armed && ctl_q.rsel) ctl_d.chip_rst = 1'b1;
        if (ctl_q.armed && cnt_zero) begin
            ctl_d.tmo = 1'b1;
            if (ctl_q.rsel) ctl_d.chip_rst = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{en: 1'b0, rsel: 1'b0, tmo: 1'b0, armed: 1'b0,
                       chip_rst: 1'b0, reload: '1};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (idx)
                REG_MODE: begin
                    rdata[MODE_EN_BIT]   = ctl_q.en;
                    rdata[MODE_RSEL_BIT] = ctl_q.rsel;
                    rdata[MODE_TMO_BIT]  = ctl_q.tmo;
                end
                REG_RELOAD: rdata[CNT_W-1:0] = ctl_q.reload;
                REG_COUNT:  rdata[CNT_W-1:0] = cnt_val;
                default:    rdata = '0;
            endcase
        end
    end

    assign chip_rst_o = ctl_q.chip_rst;

    logic             en_w, rsel_w, armed_w;
    logic [CNT_W-1:0] reload_w;
    assign en_w     = ctl_q.en;
    assign rsel_w   = ctl_q.rsel;
    assign armed_w  = ctl_q.armed;
    assign reload_w = ctl_q.reload;
endmodule

// File: rtl/wdog_core_chk.sv
module wdog_core_chk #(
    parameter int unsigned CNT_W  = 24,
    parameter int unsigned TC_MIN = 'hFF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             chip_rst_o,
    input logic             en_w,
    input logic             rsel_w,
    input logic             armed_w,
    input logic [CNT_W-1:0] cnt_val,
    input logic [CNT_W-1:0] reload_w,
    input logic             feed_ok,
    input logic             feed_bad
);
    AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst_o |=> chip_rst_o); // R8
    AST_ARM_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        armed_w |=> (armed_w && en_w)); // R9
    AST_RSEL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_w && rsel_w) |=> rsel_w); // R9
    AST_RELOAD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        reload_w >= CNT_W'(TC_MIN)); // R3
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_w && !feed_ok) |=> (cnt_val == $past(cnt_val))); // R4
    AST_FEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        feed_ok |=> (cnt_val == $past(reload_w))); // R5
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_w && !feed_ok) |=>
        (cnt_val == $past(cnt_val) || cnt_val == $past(cnt_val) - CNT_W'(1))); // R6
    AST_EXPIRE_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_w && rsel_w && cnt_val == '0) |=> chip_rst_o); // R7
    AST_BAD_FEED: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_w && rsel_w && feed_bad) |=> chip_rst_o); // R10
endmodule

bind wdog_core wdog_core_chk #(.CNT_W(CNT_W), .TC_MIN(TC_MIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chip_rst_o(chip_rst_o),
    .en_w      (en_w),
    .rsel_w    (rsel_w),
    .armed_w   (armed_w),
    .cnt_val   (cnt_val),
    .reload_w  (reload_w),
    .feed_ok   (feed_ok),
    .feed_bad  (feed_bad)
);

// File: tb/wdog_core_tb.sv
module wdog_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        chip_rst_o;

    int n_chk = 0;
    int n_err = 0;
    logic done = 1'b0;

    localparam logic [3:0] A_MODE = 4'h0, A_TC = 4'h4, A_KICK = 4'h8, A_CNT = 4'hC;

    always #10 clk = ~clk;

    wdog_core u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .chip_rst_o(chip_rst_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        addr = a; rd_en = 1'b1;
        #1;
        v = rdata;
        rd_en = 1'b0;
    endtask

    task automatic feed();
        wr(A_KICK, 32'hAA);
        wr(A_KICK, 32'h55);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] ins [9];
        int unsigned tcv;
        ins = '{32'h0, 32'h1, 32'h7F, 32'hFE, 32'hFF, 32'h100, 32'h1234,
                32'hFFFFFF, 32'hAB000123};

        do_reset();
        // R1 reset state
        chk("R1 chip_rst", {31'b0, chip_rst_o}, 32'h0);
        rd(A_MODE, v); chk("R1 mode", v, 32'h0);
        rd(A_TC, v);   chk("R1 reload", v, 32'hFFFFFF);
        rd(A_CNT, v);  chk("R1 count", v, 32'hFFFFFF);
        // R2 feed register reads zero, rdata zero without rd_en
        rd(A_KICK, v); chk("R2 feed read", v, 32'h0);
        addr = A_TC; #1; chk("R2 idle rdata", rdata, 32'h0);

        // R3 clamp sweep
        foreach (ins[i]) begin
            wr(A_TC, ins[i]);
            tcv = ins[i] & 32'hFFFFFF;
            if (tcv < 32'hFF) tcv = 32'hFF;
            rd(A_TC, v);
            chk($sformatf("R3 clamp in=0x%0h", ins[i]), v, tcv);
        end

        // R4 enable alone does nothing
        wr(A_TC, 32'h100);
        wr(A_MODE, 32'h3);
        repeat (40) @(negedge clk);
        rd(A_CNT, v); chk("R4 count frozen", v, 32'hFFFFFF);
        rd(A_MODE, v); chk("R4 mode readback", v, 32'h3);
        // R12 malformed sequence before arming
        wr(A_KICK, 32'hAA);
        wr(A_KICK, 32'h11);
        chk("R12 unarmed bad feed", {31'b0, chip_rst_o}, 32'h0);

        // R5 / R6 feed and prescaled slope
        feed();
        rd(A_CNT, v); chk("R5 reload on feed", v, 32'h100);
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            rd(A_CNT, v);
            chk($sformatf("R6 slope k=%0d", k), v, 32'h100 - k / 4);
        end

        // R9 cannot clear once armed
        wr(A_MODE, 32'h0);
        rd(A_MODE, v); chk("R9 mode locked", v, 32'h3);

        // R2 keep-alive
        for (int j = 0; j < 5; j++) begin
            repeat (800) @(negedge clk);
            feed();
        end
        chk("R2 keep alive", {31'b0, chip_rst_o}, 32'h0);

        // R7 exact expiry edge, R=0x100
        feed();
        repeat (4 * 256) @(negedge clk);
        chk("R7 before expiry", {31'b0, chip_rst_o}, 32'h0);
        rd(A_CNT, v); chk("R7 count at zero", v, 32'h0);
        @(negedge clk);
        chk("R7 expiry edge", {31'b0, chip_rst_o}, 32'h1);
        rd(A_MODE, v); chk("R7 flag", v, 32'h7);
        // R8 sticky, feeding does not clear
        repeat (20) @(negedge clk);
        feed();
        chk("R8 sticky", {31'b0, chip_rst_o}, 32'h1);
        do_reset();
        chk("R8 cleared by reset", {31'b0, chip_rst_o}, 32'h0);

        // R10 wrong second value
        wr(A_MODE, 32'h3);
        feed();
        wr(A_KICK, 32'hAA);
        chk("R10 after first key", {31'b0, chip_rst_o}, 32'h0);
        wr(A_KICK, 32'h54);
        chk("R10 wrong key", {31'b0, chip_rst_o}, 32'h1);

        // R11 abort by write to another register while armed
        do_reset();
        wr(A_MODE, 32'h3);
        feed();
        wr(A_KICK, 32'hAA);
        wr(A_TC, 32'h200);
        chk("R11 write abort", {31'b0, chip_rst_o}, 32'h1);

        // R11 abort by read while armed
        do_reset();
        wr(A_MODE, 32'h3);
        feed();
        wr(A_KICK, 32'hAA);
        @(negedge clk);
        addr = A_MODE; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R11 read abort", {31'b0, chip_rst_o}, 32'h1);

        // R11 abort while not armed drops the sequence
        do_reset();
        wr(A_MODE, 32'h3);
        wr(A_KICK, 32'hAA);
        wr(A_TC, 32'h300);
        wr(A_KICK, 32'h55);
        rd(A_CNT, v); chk("R11 lone second key", v, 32'hFFFFFF);
        chk("R11 unarmed abort", {31'b0, chip_rst_o}, 32'h0);
        feed();
        rd(A_CNT, v); chk("R11 real feed after", v, 32'h300);

        // R12 armed without reset-select; R7 flag only
        do_reset();
        wr(A_MODE, 32'h1);
        wr(A_TC, 32'hFF);
        feed();
        wr(A_KICK, 32'hAA);
        wr(A_KICK, 32'h00);
        chk("R12 no rsel bad feed", {31'b0, chip_rst_o}, 32'h0);
        repeat (1100) @(negedge clk);
        rd(A_MODE, v); chk("R7 flag without rsel", v, 32'h5);
        chk("R7 no reset without rsel", {31'b0, chip_rst_o}, 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule